// File: doc/BRIEF.md
# Linked-List DMA Descriptor Loader

This block is the descriptor engine of one DMA channel. Software programs a small register window with a source address, a destination address, a byte count, a link pointer and a control word. Setting the enable bit of the control word starts the channel. The engine hands each transfer to a data mover through a start/done handshake. When the mover reports completion, the engine looks at the link pointer. A zero pointer ends the run and drops busy. Any other value makes the engine read a 16-word descriptor from memory at that address, load it into the working registers and start the next transfer.

A chain whose last link points back to an earlier descriptor runs forever, which serves a ring of buffers. The link register can be read back at any time. During a fetch it holds the address of the descriptor being loaded. While a transfer runs it holds the address of the next descriptor, which is what software needs to locate its position in the chain. The mover itself, bus timing and two-dimensional stepping are outside the block.

Top module: `dma_chain_loader`

## Requirements
- R1: After reset, busy, tc_pulse, mem_req and mov_start are low, and every register in the window reads zero.
- R2: While idle, a write stores into the addressed register: 0x00 source, 0x04 destination, 0x08 byte count, 0x0C plane count, 0x10 source stride, 0x14 destination stride, 0x1C link, 0x20 control. Every other offset reads zero and ignores writes. Bit 0 of a control read shows busy, and the other bits show the stored word. A control write with bit 0 clear does not start the channel.
- R3: A control write with bit 0 set, made while idle, raises busy at the next clock edge. In the cycle that follows, it presents mov_start with the register values on mov_src, mov_dst and mov_len.
- R4: The byte count holds only its low 16 bits. Higher bits of a write are dropped, both on readback and on mov_len.
- R5: A descriptor whose byte count is zero completes without any mov_start pulse. It still follows its link and still raises its interrupt pulse.
- R6: When a transfer completes and the link is zero, busy falls at that clock edge and the channel waits for a new start.
- R7: With a nonzero link, the engine issues 16 word reads at link, link+4, … link+60. It holds each address with mem_req until a cycle that has mem_rvalid.
- R8: The working registers change only after the 16th word has arrived. During a fetch, the window still shows the previous values, and the link register shows the fetch address.
- R9: Descriptor word 0 loads the source, word 1 the destination, word 2 the byte count, words 3 to 5 the plane count and the two strides, word 7 the link, and word 8 the control word. Words 6 and 9 to 15 are ignored.
- R10: A descriptor whose control word has bit 4 or bit 5 set produces exactly one one-cycle tc_pulse, in the cycle after that descriptor completes. Other descriptors produce none.
- R11: A link that points back into the chain repeats the chain without end, and busy stays high.
- R12: Register writes made while busy have no effect. This includes a second enable.
- R13: The plane count and the two strides are storage only. They never change the values presented to the mover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Byte offset in the register window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid; completes the requested word |
| mem_rdata | input | 32 | Read data |
| mov_start | output | 1 | One-cycle start to the data mover |
| mov_src | output | AW | Source address of the transfer |
| mov_dst | output | AW | Destination address of the transfer |
| mov_len | output | LW | Byte count of the transfer |
| mov_done | input | 1 | Mover reports the transfer finished |
| busy | output | 1 | Channel is running |
| tc_pulse | output | 1 | Terminal-count pulse |

## Verification
The hardest state to reach from the ports is a fetch that is still in progress while the window is read. The stale working registers and the link-as-fetch-address view only exist during those cycles. The stimulus waits for mem_req and reads the window there, while the memory model stretches each fetch with periodic stalls. The same stalls make the address-hold behaviour observable. The loop case is reached by a two-entry ring, and the bench follows it for three laps. It counts pulses only from the descriptors that set the interrupt bits.

// File: rtl/dma_chain_loader.sv
module dma_chain_loader #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int DESC_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          mov_start,
  output logic [AW-1:0] mov_src,
  output logic [AW-1:0] mov_dst,
  output logic [LW-1:0] mov_len,
  input  logic          mov_done,
  output logic          busy,
  output logic          tc_pulse
);
  localparam int IW = $clog2(DESC_WORDS);
  localparam logic [IW-1:0] LAST_W = IW'(DESC_WORDS - 1);

  localparam logic [5:0] A_SRC  = 6'h00;
  localparam logic [5:0] A_DST  = 6'h04;
  localparam logic [5:0] A_CNT  = 6'h08;
  localparam logic [5:0] A_PLN  = 6'h0C;
  localparam logic [5:0] A_SSTR = 6'h10;
  localparam logic [5:0] A_DSTR = 6'h14;
  localparam logic [5:0] A_LINK = 6'h1C;
  localparam logic [5:0] A_CTRL = 6'h20;

  localparam logic [IW-1:0] D_SRC  = IW'(0);
  localparam logic [IW-1:0] D_DST  = IW'(1);
  localparam logic [IW-1:0] D_CNT  = IW'(2);
  localparam logic [IW-1:0] D_PLN  = IW'(3);
  localparam logic [IW-1:0] D_SSTR = IW'(4);
  localparam logic [IW-1:0] D_DSTR = IW'(5);
  localparam logic [IW-1:0] D_LINK = IW'(7);
  localparam logic [IW-1:0] D_CTRL = IW'(8);

  typedef enum logic [1:0] {S_IDLE, S_KICK, S_RUN, S_FETCH} state_t;
  state_t state;

  logic [AW-1:0] src_q, dst_q, link_q;
  logic [LW-1:0] cnt_q;
  logic [31:0]   pln_q, sstr_q, dstr_q, ctrl_q;

  logic [AW-1:0] f_src, f_dst, f_link;
  logic [LW-1:0] f_cnt;
  logic [31:0]   f_pln, f_sstr, f_dstr, f_ctrl;
  logic [IW-1:0] widx;
  logic          tc_q;

  logic wr_ok, fin, beat;

  assign busy      = (state != S_IDLE);
  assign wr_ok     = cfg_we && (state == S_IDLE);
  assign fin       = ((state == S_KICK) && (cnt_q == '0)) || ((state == S_RUN) && mov_done);
  assign mem_req   = (state == S_FETCH);
  assign beat      = mem_req && mem_rvalid;
  assign mem_addr  = link_q + (AW'(widx) << 2);
  assign mov_start = (state == S_KICK) && (cnt_q != '0);
  assign mov_src   = src_q;
  assign mov_dst   = dst_q;
  assign mov_len   = cnt_q;
  assign tc_pulse  = tc_q;

  always_comb begin
    case (cfg_addr)
      A_SRC:   cfg_rdata = 32'(src_q);
      A_DST:   cfg_rdata = 32'(dst_q);
      A_CNT:   cfg_rdata = 32'(cnt_q);
      A_PLN:   cfg_rdata = pln_q;
      A_SSTR:  cfg_rdata = sstr_q;
      A_DSTR:  cfg_rdata = dstr_q;
      A_LINK:  cfg_rdata = 32'(link_q);
      A_CTRL:  cfg_rdata = {ctrl_q[31:1], busy};
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      pln_q  <= '0;
      sstr_q <= '0;
      dstr_q <= '0;
      link_q <= '0;
      ctrl_q <= '0;
      f_src  <= '0;
      f_dst  <= '0;
      f_cnt  <= '0;
      f_pln  <= '0;
      f_sstr <= '0;
      f_dstr <= '0;
      f_link <= '0;
      f_ctrl <= '0;
      widx   <= '0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= fin && (ctrl_q[5:4] != 2'b00);
      case (state)
        S_IDLE: if (wr_ok) begin
          case (cfg_addr)
            A_SRC:  src_q  <= cfg_wdata[AW-1:0];
            A_DST:  dst_q  <= cfg_wdata[AW-1:0];
            A_CNT:  cnt_q  <= cfg_wdata[LW-1:0];
            A_PLN:  pln_q  <= cfg_wdata;
            A_SSTR: sstr_q <= cfg_wdata;
            A_DSTR: dstr_q <= cfg_wdata;
            A_LINK: link_q <= cfg_wdata[AW-1:0];
            A_CTRL: begin
              ctrl_q <= cfg_wdata;
              if (cfg_wdata[0]) state <= S_KICK;
            end
            default: ;
          endcase
        end
        S_KICK, S_RUN: begin
          if (fin) begin
            widx  <= '0;
            state <= (link_q == '0) ? S_IDLE : S_FETCH;
          end else begin
            state <= S_RUN;
          end
        end
        S_FETCH: if (beat) begin
          case (widx)
            D_SRC:  f_src  <= mem_rdata[AW-1:0];
            D_DST:  f_dst  <= mem_rdata[AW-1:0];
            D_CNT:  f_cnt  <= mem_rdata[LW-1:0];
            D_PLN:  f_pln  <= mem_rdata;
            D_SSTR: f_sstr <= mem_rdata;
            D_DSTR: f_dstr <= mem_rdata;
            D_LINK: f_link <= mem_rdata[AW-1:0];
            D_CTRL: f_ctrl <= mem_rdata;
            default: ;
          endcase
          if (widx == LAST_W) begin
            src_q  <= f_src;
            dst_q  <= f_dst;
            cnt_q  <= f_cnt;
            pln_q  <= f_pln;
            sstr_q <= f_sstr;
            dstr_q <= f_dstr;
            link_q <= f_link;
            ctrl_q <= f_ctrl;
            widx   <= '0;
            state  <= S_KICK;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_loader_chk.sv
module dma_chain_loader_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [5:0]    cfg_addr,
  input logic [31:0]   cfg_wdata,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          mov_start,
  input logic          busy,
  input logic          tc_pulse
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !mov_start));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mov_start |-> busy);

  assert_rise_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_we && (cfg_addr == 6'h20) && cfg_wdata[0]));

  assert_fetch_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (busy && !mov_start));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_tc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);
endmodule

bind dma_chain_loader dma_chain_loader_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .mov_start(mov_start), .busy(busy),
  .tc_pulse(tc_pulse)
);

// File: tb/tb_dma_chain_loader.sv
module tb_dma_chain_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mov_start;
  logic [31:0] mov_src, mov_dst;
  logic [15:0] mov_len;
  logic        mov_done = 1'b0;
  logic        busy, tc_pulse;

  dma_chain_loader dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mov_start(mov_start), .mov_src(mov_src), .mov_dst(mov_dst),
    .mov_len(mov_len), .mov_done(mov_done), .busy(busy), .tc_pulse(tc_pulse)
  );

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  typedef struct packed { logic [31:0] s; logic [31:0] d; logic [15:0] n; } item_t;
  item_t       exp_q[$];
  logic [31:0] fetch_q[$];
  bit          drain_ok = 1'b0;
  int          tc_seen = 0;
  logic [31:0] mem [0:255];

  // scoreboard monitor for mover starts and pulses
  always @(negedge clk) begin
    if (rst_n && tc_pulse) tc_seen++;
    if (rst_n && mov_start) begin
      if (exp_q.size() == 0) begin
        if (!drain_ok) chk(1'b0, "R3 unexpected mov_start", mov_src, 32'h0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(mov_src == e.s, "R3 R9 R13 mov_src", mov_src, e.s);
        chk(mov_dst == e.d, "R3 R9 R13 mov_dst", mov_dst, e.d);
        chk(mov_len == e.n, "R4 mov_len", 32'(mov_len), 32'(e.n));
      end
    end
  end

  // memory model with periodic stalls, and fetch address monitor
  int          stall = 0;
  int          wk = 0;
  logic [31:0] cur_base = '0;
  always @(negedge clk) begin
    stall++;
    mem_rvalid = mem_req && (stall % 3 != 1);
    mem_rdata  = mem[mem_addr[9:2]];
    if (mem_rvalid) begin
      if (wk == 0) begin
        if (fetch_q.size() > 0) cur_base = fetch_q.pop_front();
        else begin
          cur_base = mem_addr;
          if (!drain_ok) chk(1'b0, "R7 unexpected fetch", mem_addr, 32'h0);
        end
      end
      chk(mem_addr == cur_base + 32'(4 * wk), "R7 fetch address", mem_addr, cur_base + 32'(4 * wk));
      wk = (wk + 1) % 16;
    end
  end

  // mock mover
  int mv_cnt = 0;
  always @(negedge clk) begin
    mov_done = 1'b0;
    if (mv_cnt == 1) mov_done = 1'b1;
    if (mv_cnt > 0) mv_cnt--;
    if (mov_start) mv_cnt = 3;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == exp, req, cfg_rdata, exp);
  endtask

  task automatic put_desc(input int base, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] pl, input logic [31:0] ss,
                          input logic [31:0] ds, input logic [31:0] nx, input logic [31:0] ct);
    int w;
    w = base >> 2;
    for (int k = 0; k < 16; k++) mem[w + k] = 32'hBAD0_0000 + 32'(k);
    mem[w + 0] = s;  mem[w + 1] = d;  mem[w + 2] = n;  mem[w + 3] = pl;
    mem[w + 4] = ss; mem[w + 5] = ds; mem[w + 7] = nx; mem[w + 8] = ct;
  endtask

  task automatic wait_idle(input string req);
    int t;
    t = 0;
    @(negedge clk);
    while (busy && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(!busy, req, 32'(busy), 32'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int tc0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(!busy && !tc_pulse && !mem_req && !mov_start, "R1 outputs after reset",
        {28'h0, busy, tc_pulse, mem_req, mov_start}, 32'h0);
    rd_chk(6'h00, 32'h0, "R1 source reg zero");
    rd_chk(6'h1C, 32'h0, "R1 link reg zero");
    rd_chk(6'h20, 32'h0, "R1 control reg zero");

    // R2 / R4 register access while idle
    wr(6'h00, 32'h1111_0000); rd_chk(6'h00, 32'h1111_0000, "R2 source readback");
    wr(6'h04, 32'h2222_0000); rd_chk(6'h04, 32'h2222_0000, "R2 destination readback");
    wr(6'h0C, 32'h0000_0033); rd_chk(6'h0C, 32'h0000_0033, "R2 plane readback");
    wr(6'h10, 32'h0000_0044); rd_chk(6'h10, 32'h0000_0044, "R2 source stride readback");
    wr(6'h14, 32'h0000_0055); rd_chk(6'h14, 32'h0000_0055, "R2 destination stride readback");
    wr(6'h18, 32'hFFFF_FFFF); rd_chk(6'h18, 32'h0, "R2 unused offset");
    wr(6'h08, 32'h0001_2345); rd_chk(6'h08, 32'h0000_2345, "R4 count truncated");
    wr(6'h20, 32'h0000_0030);
    chk(!busy, "R2 control without enable", 32'(busy), 32'h0);
    rd_chk(6'h20, 32'h0000_0030, "R2 control readback");

    // R3 R6 R10 R12 single descriptor
    wr(6'h00, 32'h0000_1000);
    wr(6'h04, 32'h0000_2000);
    wr(6'h08, 32'h0001_0040);
    wr(6'h1C, 32'h0);
    exp_q.push_back({32'h1000, 32'h2000, 16'h0040});
    tc0 = tc_seen;
    wr(6'h20, 32'h0000_0031);
    chk(busy, "R3 busy after enable", 32'(busy), 32'h1);
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h20, 32'h0000_0001);
    wait_idle("R6 idle after last descriptor");
    chk(tc_seen - tc0 == 1, "R10 one pulse for flagged descriptor", 32'(tc_seen - tc0), 32'h1);
    rd_chk(6'h00, 32'h0000_1000, "R12 write while busy ignored");
    chk(exp_q.size() == 0, "R12 no second start", 32'(exp_q.size()), 32'h0);

    // R7 R8 R9 R13 three-entry chain
    put_desc(32'h100, 32'hA100, 32'hB100, 32'h30, 32'h5, 32'h6, 32'h7, 32'h140, 32'h01);
    put_desc(32'h140, 32'hA200, 32'hB200, 32'h44, 32'h11, 32'h22, 32'h33, 32'h0, 32'h31);
    wr(6'h00, 32'hA000); wr(6'h04, 32'hB000); wr(6'h08, 32'h20); wr(6'h1C, 32'h100);
    exp_q.push_back({32'hA000, 32'hB000, 16'h0020});
    exp_q.push_back({32'hA100, 32'hB100, 16'h0030});
    exp_q.push_back({32'hA200, 32'hB200, 16'h0044});
    fetch_q.push_back(32'h100);
    fetch_q.push_back(32'h140);
    tc0 = tc_seen;
    wr(6'h20, 32'h0000_0001);
    while (!mem_req) @(negedge clk);
    rd_chk(6'h00, 32'hA000, "R8 source unchanged during fetch");
    rd_chk(6'h1C, 32'h100, "R8 link shows fetch address");
    wait_idle("R6 chain ends on zero link");
    chk(exp_q.size() == 0, "R7 all chained transfers started", 32'(exp_q.size()), 32'h0);
    chk(fetch_q.size() == 0, "R7 all descriptors fetched", 32'(fetch_q.size()), 32'h0);
    chk(tc_seen - tc0 == 1, "R10 pulse only from last descriptor", 32'(tc_seen - tc0), 32'h1);
    rd_chk(6'h0C, 32'h11, "R9 plane loaded from word 3");
    rd_chk(6'h10, 32'h22, "R9 source stride from word 4");
    rd_chk(6'h14, 32'h33, "R9 destination stride from word 5");
    rd_chk(6'h1C, 32'h0, "R9 link from word 7");
    rd_chk(6'h20, 32'h30, "R9 control from word 8");

    // R5 zero-length descriptor
    put_desc(32'h180, 32'hC100, 32'hD100, 32'h10, 32'h0, 32'h0, 32'h0, 32'h0, 32'h01);
    wr(6'h00, 32'hC000); wr(6'h08, 32'h0); wr(6'h1C, 32'h180);
    exp_q.push_back({32'hC100, 32'hD100, 16'h0010});
    fetch_q.push_back(32'h180);
    tc0 = tc_seen;
    wr(6'h20, 32'h0000_0011);
    wait_idle("R5 zero-length chain finishes");
    chk(exp_q.size() == 0, "R5 only the nonzero descriptor started", 32'(exp_q.size()), 32'h0);
    chk(tc_seen - tc0 == 1, "R5 zero-length descriptor still pulses", 32'(tc_seen - tc0), 32'h1);

    // R11 cyclic ring
    put_desc(32'h1C0, 32'hE100, 32'hF100, 32'h8, 32'h0, 32'h0, 32'h0, 32'h200, 32'h11);
    put_desc(32'h200, 32'hE200, 32'hF200, 32'hC, 32'h0, 32'h0, 32'h0, 32'h1C0, 32'h21);
    wr(6'h00, 32'hE000); wr(6'h04, 32'hF000); wr(6'h08, 32'h4); wr(6'h1C, 32'h1C0);
    exp_q.push_back({32'hE000, 32'hF000, 16'h0004});
    for (int lap = 0; lap < 3; lap++) begin
      exp_q.push_back({32'hE100, 32'hF100, 16'h0008});
      exp_q.push_back({32'hE200, 32'hF200, 16'h000C});
      fetch_q.push_back(32'h1C0);
      fetch_q.push_back(32'h200);
    end
    tc0 = tc_seen;
    wr(6'h20, 32'h0000_0001);
    begin
      int t;
      t = 0;
      while (exp_q.size() != 0 && t < 20000) begin
        @(negedge clk);
        t++;
      end
    end
    drain_ok = 1'b1;
    chk(exp_q.size() == 0, "R11 ring laps completed", 32'(exp_q.size()), 32'h0);
    repeat (8) @(negedge clk);
    chk(busy, "R11 ring keeps running", 32'(busy), 32'h1);
    chk(tc_seen - tc0 == 6, "R11 R10 pulses per ring descriptor", 32'(tc_seen - tc0), 32'h6);

    report();
    $finish;
  end
endmodule